// File: doc/BRIEF.md
# Programmable Feedback and Reference Divider Chain

This block holds the digital counters of one frequency-synthesis loop. A reference divider turns every 65th reference event into a one-cycle update strobe. A feedback divider turns every N-th oscillator event into a one-cycle feedback strobe. Both strobes go to a phase comparator that is outside this block. With a 13 MHz reference the strobe rate is 200 kHz, so the loop locks its oscillator at N x 200 kHz.

The feedback divider models a two-modulus prescaler (P and P+1 events) followed by a swallow counter and a main counter. Software writes only N. The block derives the main count M = N div P and the swallow count S = N mod P by itself. In each division cycle the first S prescaler cycles use modulus P+1 and the remaining M-S cycles use modulus P. N values too small for that split are rejected. A valid new N waits until the division cycle in progress has finished, so no shortened or stretched cycle is ever produced.

Everything runs on one fast clock. Reference and oscillator events arrive as qualifier inputs (`ref_tick_i`, `osc_tick_i`). All counting is in events, not in clock cycles.

Top module: `pll_div_chain`

## Requirements
- R1: `ref_pulse_o` is high for exactly one clock cycle. It rises in the cycle after every 65th clock edge at which `ref_tick_i` was high, counting from reset. Edges with `ref_tick_i` low are not counted.
- R2: `fb_pulse_o` is high for one clock cycle in the cycle after every N-th clock edge at which `osc_tick_i` was high, where N is the active divide value. Edges with `osc_tick_i` low are not counted.
- R3: The divider splits N into M = N div P prescaler cycles. The first S = N mod P of them last P+1 events and the rest last P events (defaults P = 32). The period is exactly N for S = 0 (N = 992) and for S = P-1 (N = 1023).
- R4: A load (`n_load_i` high for one cycle) with N < P*(P-1), which is 992 by default, is rejected. `n_err_o` is then high for one cycle in the next cycle, no acknowledge follows, and the active N is unchanged. A valid load never raises `n_err_o`.
- R5: A valid loaded N takes effect only at the end of the division cycle in progress. `n_ack_o` is high in the same cycle as the `fb_pulse_o` that ends the last old-N period. The next period uses the new N.
- R6: If a second valid N is loaded before the first one has taken effect, only the later value is applied, with a single acknowledge.
- R7: While `rst_ni` is low all outputs are low. After reset the active N is `N_RESET` (1024 by default), so the first feedback period is 1024 events.
- R8: Gaps in the tick inputs change neither ratio. With events on every second clock, the periods are still 65 and N events.

Maximum N is 2^N_W-1, with N_W = 18 by default (16 and 17 are supported variants).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference event qualifier |
| osc_tick_i | input | 1 | Oscillator event qualifier |
| n_i | input | N_W | Feedback divide value to load |
| n_load_i | input | 1 | Load strobe for `n_i` |
| ref_pulse_o | output | 1 | Update strobe, one per 65 reference events |
| fb_pulse_o | output | 1 | Feedback strobe, one per N oscillator events |
| n_ack_o | output | 1 | New N became active (end of the old cycle) |
| n_err_o | output | 1 | Rejected load: N below the split limit |

## Verification
The assertions check on every cycle that the reference strobe follows the 65th counted event. They also check that the feedback strobe is never wider than one cycle and that an acknowledge only occurs together with a feedback strobe. A further check is that the remaining swallow count never exceeds the remaining main count, which is what keeps every valid split free of gaps. The exact period for a given N, the S = 0 and S = P-1 split corners, and the rejection of a value below the limit can only be shown by the bench scenarios. The same holds for a last-write-wins override and for immunity to tick gaps, all of which the bench checks by counting events between strobes.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned REF_RATIO    = 65;
  localparam int unsigned DEF_PRESCALE = 32;
  localparam int unsigned DEF_N_W      = 18;
  localparam int unsigned DEF_N_RESET  = 1024;

  // smallest N whose swallow count never exceeds its main count
  function automatic int unsigned min_split_n(input int unsigned p);
    return p * (p - 1);
  endfunction
endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
  parameter int unsigned RATIO = 65
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int unsigned RW = $clog2(RATIO);
  localparam logic [RW-1:0] LAST = RW'(RATIO - 1);

  logic [RW-1:0] cnt_q;
  logic          wrap;

  assign wrap = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= wrap ? '0 : cnt_q + RW'(1);
      pulse_o <= wrap;
    end
  end

  a_r1_ref_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> ($past(tick_i) && $past(cnt_q) == LAST && cnt_q == '0));
  a_r1_ref_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o || (RATIO == 1));
endmodule

// File: rtl/pll_n_split.sv
module pll_n_split #(
  parameter int unsigned N_W = 18,
  parameter int unsigned P   = 32,
  parameter int unsigned MW  = 14,
  parameter int unsigned SW  = 5
) (
  input  logic [N_W-1:0] n_i,
  output logic [MW-1:0]  main_o,
  output logic [SW-1:0]  swl_o,
  output logic           ok_o
);
  localparam logic [N_W-1:0] MIN_N = N_W'(pll_div_pkg::min_split_n(P));

  generate
    if ((P & (P - 1)) == 0) begin : g_pow2
      // power-of-two modulus: split is pure wiring
      logic [N_W-1:0] shifted;
      assign shifted = n_i >> SW;
      assign main_o  = MW'(shifted);
      assign swl_o   = n_i[SW-1:0];
    end else begin : g_div
      localparam logic [N_W-1:0] P_N = N_W'(P);
      logic [N_W-1:0] quo, rem;
      assign quo    = n_i / P_N;
      assign rem    = n_i % P_N;
      assign main_o = MW'(quo);
      assign swl_o  = SW'(rem);
    end
  endgenerate

  assign ok_o = (n_i >= MIN_N);
endmodule

// File: rtl/pll_fb_div.sv
module pll_fb_div #(
  parameter int unsigned P        = 32,
  parameter int unsigned MW       = 14,
  parameter int unsigned SW       = 5,
  parameter int unsigned RST_MAIN = 32,
  parameter int unsigned RST_SWL  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic          ok_i,
  input  logic [MW-1:0] main_i,
  input  logic [SW-1:0] swl_i,
  output logic          pulse_o,
  output logic          ack_o,
  output logic          err_o
);
  localparam int unsigned PW = $clog2(P + 1);
  localparam logic [PW-1:0] PRE_LONG  = PW'(P);      // P+1 events
  localparam logic [PW-1:0] PRE_SHORT = PW'(P - 1);  // P events

  logic [PW-1:0] pre_q, pre_d;
  logic [MW-1:0] main_q, main_d, act_main_q, pend_main_q, nxt_main;
  logic [SW-1:0] swl_q, swl_d, act_swl_q, pend_swl_q, nxt_swl;
  logic          pend_q, pre_end, cyc_end, take;

  assign take     = load_i && ok_i;
  assign pre_end  = tick_i && (pre_q == '0);
  assign cyc_end  = pre_end && (main_q == MW'(1));
  assign nxt_main = pend_q ? pend_main_q : act_main_q;
  assign nxt_swl  = pend_q ? pend_swl_q  : act_swl_q;

  always_comb begin
    main_d = main_q;
    swl_d  = swl_q;
    pre_d  = pre_q;
    if (tick_i) begin
      if (pre_q != '0) begin
        pre_d = pre_q - PW'(1);
      end else begin
        if (main_q == MW'(1)) begin
          main_d = nxt_main;
          swl_d  = nxt_swl;
        end else begin
          main_d = main_q - MW'(1);
          swl_d  = swl_q - SW'(swl_q != '0);
        end
        pre_d = (swl_d != '0) ? PRE_LONG : PRE_SHORT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q       <= (RST_SWL != 0) ? PRE_LONG : PRE_SHORT;
      main_q      <= MW'(RST_MAIN);
      swl_q       <= SW'(RST_SWL);
      act_main_q  <= MW'(RST_MAIN);
      act_swl_q   <= SW'(RST_SWL);
      pend_main_q <= '0;
      pend_swl_q  <= '0;
      pend_q      <= 1'b0;
      pulse_o     <= 1'b0;
      ack_o       <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      main_q <= main_d;
      swl_q  <= swl_d;
      if (cyc_end) begin
        act_main_q <= nxt_main;
        act_swl_q  <= nxt_swl;
        pend_q     <= take;
      end else if (take) begin
        pend_q <= 1'b1;
      end
      if (take) begin
        pend_main_q <= main_i;
        pend_swl_q  <= swl_i;
      end
      pulse_o <= cyc_end;
      ack_o   <= cyc_end && pend_q;
      err_o   <= load_i && !ok_i;
    end
  end

  a_r2_fb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  a_r5_ack_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> pulse_o);
  a_r3_swl_within_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MW'(swl_q) <= main_q) && (MW'(act_swl_q) <= act_main_q));
  a_r3_pre_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_LONG);
  a_r4_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(load_i));
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
  parameter int unsigned N_W     = pll_div_pkg::DEF_N_W,
  parameter int unsigned P       = pll_div_pkg::DEF_PRESCALE,
  parameter int unsigned N_RESET = pll_div_pkg::DEF_N_RESET
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_tick_i,
  input  logic           osc_tick_i,
  input  logic [N_W-1:0] n_i,
  input  logic           n_load_i,
  output logic           ref_pulse_o,
  output logic           fb_pulse_o,
  output logic           n_ack_o,
  output logic           n_err_o
);
  localparam int unsigned SW = $clog2(P);
  localparam int unsigned MW = N_W - SW + 1;

  logic [MW-1:0] split_main;
  logic [SW-1:0] split_swl;
  logic          split_ok;

  pll_ref_div #(.RATIO(pll_div_pkg::REF_RATIO)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ref_tick_i),
    .pulse_o(ref_pulse_o)
  );

  pll_n_split #(.N_W(N_W), .P(P), .MW(MW), .SW(SW)) u_split (
    .n_i   (n_i),
    .main_o(split_main),
    .swl_o (split_swl),
    .ok_o  (split_ok)
  );

  pll_fb_div #(
    .P(P), .MW(MW), .SW(SW),
    .RST_MAIN(N_RESET / P), .RST_SWL(N_RESET % P)
  ) u_fb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (osc_tick_i),
    .load_i (n_load_i),
    .ok_i   (split_ok),
    .main_i (split_main),
    .swl_i  (split_swl),
    .pulse_o(fb_pulse_o),
    .ack_o  (n_ack_o),
    .err_o  (n_err_o)
  );

  a_r4_err_excludes_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_err_o |-> !$past(split_ok));
endmodule

// File: tb/pll_div_chain_bench.sv
module pll_div_chain_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, osc_tick = 1'b0;
  logic [N_W-1:0] n_val = '0;
  logic n_load = 1'b0;
  logic ref_pulse, fb_pulse, n_ack, n_err;

  int checks = 0, errors = 0;
  bit gap_mode = 1'b0;
  int fb_ev = 0, fb_last = 0, fb_cnt = 0;
  int ref_ev = 0, ref_last = 0, ref_cnt = 0;
  int ack_cnt = 0, ack_lone = 0, wide_bad = 0, err_cnt = 0;
  logic prev_fb = 1'b0, prev_ref = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_div_chain u_pll_div_chain (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .osc_tick_i(osc_tick),
    .n_i(n_val), .n_load_i(n_load), .ref_pulse_o(ref_pulse), .fb_pulse_o(fb_pulse),
    .n_ack_o(n_ack), .n_err_o(n_err)
  );

  // event accounting and tick driving, on every falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        fb_ev = 0; ref_ev = 0; osc_tick = 1'b0; ref_tick = 1'b0;
        prev_fb = 1'b0; prev_ref = 1'b0;
      end else begin
        fb_ev  += int'(osc_tick);
        ref_ev += int'(ref_tick);
        if (fb_pulse)  begin fb_last = fb_ev; fb_ev = 0; fb_cnt++; end
        if (ref_pulse) begin ref_last = ref_ev; ref_ev = 0; ref_cnt++; end
        if ((fb_pulse && prev_fb) || (ref_pulse && prev_ref)) wide_bad++;
        if (n_ack) begin ack_cnt++; if (!fb_pulse) ack_lone++; end
        if (n_err) err_cnt++;
        prev_fb = fb_pulse; prev_ref = ref_pulse;
        osc_tick = gap_mode ? ~osc_tick : 1'b1;
        ref_tick = gap_mode ? ~ref_tick : 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fb(input int k);
    int start = fb_cnt;
    int guard = 0;
    while (fb_cnt < start + k) begin
      @(negedge clk); #1;
      guard++;
      if (guard > 20000) begin
        check(1'b0, "watchdog_fb", fb_cnt, start + k);
        return;
      end
    end
  endtask

  task automatic wait_ack(input int prev);
    int guard = 0;
    while (ack_cnt == prev) begin
      @(negedge clk); #1;
      guard++;
      if (guard > 20000) begin
        check(1'b0, "watchdog_ack", ack_cnt, prev + 1);
        return;
      end
    end
  endtask

  task automatic load_n(input int v);
    @(negedge clk); #1;
    n_val = N_W'(v); n_load = 1'b1;
    @(negedge clk); #1;
    n_load = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!ref_pulse && !fb_pulse && !n_ack && !n_err, "R7 reset outputs",
          int'({ref_pulse, fb_pulse, n_ack, n_err}), 0);
    rst_n = 1'b1;
    wait_fb(1);
    check(fb_last == 1024, "R7 reset N period", fb_last, 1024);
    wait_fb(1);
    check(fb_last == 1024, "R2 steady default period", fb_last, 1024);
    check(ref_last == 65, "R1 ref ratio", ref_last, 65);
    check(ref_cnt >= 30, "R1 ref pulse count", ref_cnt, 30);
  endtask

  // load valid N mid-cycle: old period completes, ack coincides, then new period
  task automatic t_apply(input int nv, input int old_n, input string req);
    int a0 = ack_cnt;
    int e0 = err_cnt;
    wait_fb(1);
    repeat (100) @(negedge clk);
    load_n(nv);
    check(!n_err, {req, " no err on valid"}, int'(n_err), 0);
    wait_ack(a0);
    check(fb_last == old_n, "R5 old cycle completes", fb_last, old_n);
    check(ack_cnt == a0 + 1, "R5 one ack", ack_cnt, a0 + 1);
    wait_fb(1);
    check(fb_last == nv, req, fb_last, nv);
    wait_fb(1);
    check(fb_last == nv, req, fb_last, nv);
    check(err_cnt == e0, "R4 valid load raises no err", err_cnt, e0);
  endtask

  task automatic t_reject(input int bad, input int cur);
    int a0 = ack_cnt;
    load_n(bad);
    check(n_err == 1'b1, "R4 err pulse", int'(n_err), 1);
    @(negedge clk); #1;
    check(n_err == 1'b0, "R4 err one cycle", int'(n_err), 0);
    wait_fb(2);
    check(ack_cnt == a0, "R4 no ack on bad N", ack_cnt, a0);
    check(fb_last == cur, "R4 N unchanged", fb_last, cur);
  endtask

  task automatic t_override;
    int a0 = ack_cnt;
    wait_fb(1);
    repeat (10) @(negedge clk);
    load_n(1500);
    repeat (5) @(negedge clk);
    load_n(2000);
    wait_ack(a0);
    wait_fb(1);
    check(fb_last == 2000, "R6 later N wins", fb_last, 2000);
    check(ack_cnt == a0 + 1, "R6 single ack", ack_cnt, a0 + 1);
  endtask

  task automatic t_gaps;
    gap_mode = 1'b1;
    wait_fb(2);
    check(fb_last == 1200, "R8 fb ratio with gaps", fb_last, 1200);
    check(ref_last == 65, "R8 ref ratio with gaps", ref_last, 65);
    gap_mode = 1'b0;
    wait_fb(2);
    check(fb_last == 1200, "R8 fb ratio after gaps", fb_last, 1200);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_apply(1000, 1024, "R2 N=1000 period");
    t_apply(992, 1000, "R3 S=0 split period");
    t_apply(1023, 992, "R3 S=P-1 split period");
    t_reject(991, 1023);
    t_reject(5, 1023);
    t_apply(5000, 1023, "R2 N=5000 period");
    t_override();
    t_apply(1200, 2000, "R2 N=1200 period");
    t_gaps();
    check(wide_bad == 0, "R1 R2 single-cycle pulses", wide_bad, 0);
    check(ack_lone == 0, "R5 ack with fb pulse", ack_lone, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule